// File: doc/BRIEF.md
# ASID-Hashed Address Translation Lookup

This block turns a 32-bit virtual address into a physical address for 4 KiB pages. The top three address bits first pick a region. The two fixed windows skip translation and map directly into the low 512 MiB of physical space. One of these windows is cached and the other is uncached. The user region and the upper kernel region are translated through a 4-way, 32-set translation buffer. The control region at the top of the map returns a flag only and no translation. The topmost 64 MiB of the user region is reserved, so any access there is reported as an address error.

Software fills the buffer one entry at a time and names the set and the way for each write. A single pulse clears every entry. The set index depends on a mode input. With the mode off, the index is taken directly from the low virtual-page bits. With the mode on, those bits are XORed with the low bits of the current address-space identifier. In that case the hashed page bits are not stored in the entry, because the set the entry sits in already encodes them. A lookup request is answered exactly one cycle later, and the answer carries one of five outcomes.

Top module: `tlb_asid_lookup`

## Requirements
- R1: After reset, no response is flagged, and a translated-region lookup misses because every entry is empty.
- R2: A request accepted on one clock edge gives a response with rsp_valid=1 on the next edge. When no request is made, rsp_valid=0 and every outcome flag is 0.
- R3: For VA[31:29]=3'b100, the block reports a hit with rsp_pa = {3'b000, VA[28:0]} and rsp_cacheable=1. The buffer is not used.
- R4: For VA[31:29]=3'b101, the block reports a hit with rsp_pa = {3'b000, VA[28:0]} and rsp_cacheable=0.
- R5: For VA[31:29]=3'b111, only rsp_ctrl is set. Hit, miss and address error stay 0.
- R6: For VA[31:26]=6'b011111 (0x7C000000 to 0x7FFFFFFF), only rsp_addr_err is set. Addresses below 0x7C000000 in the user region are translated.
- R7: In a translated region, a way hits when it is valid, its tag matches and its ASID matches. The result is then rsp_pa = {PPN, VA[11:0]} and rsp_cacheable is the entry's cacheable bit.
- R8: An entry whose ASID differs from cur_asid misses unless its shared bit is set. A shared entry hits under any ASID.
- R9: With index_mode=1, the set is cur_asid[4:0] XOR VA[16:12], and the tag compare uses only VPN[31:17].
- R10: With index_mode=0, the set is VA[16:12] and the whole of VPN[31:12] is compared.
- R11: When more than one way in the selected set matches, only rsp_multi_hit is set. Exactly one outcome flag is set in each response.
- R12: A pulse on inval_all clears every valid bit in one cycle. It takes priority over a write in the same cycle.
- R13: A write to a set and way replaces whatever that slot held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_asid | input | 8 | Current address-space identifier |
| index_mode | input | 1 | 1 selects the ASID-hashed set index |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Load one buffer entry |
| wr_set | input | 5 | Set to load |
| wr_way | input | 2 | Way to load |
| wr_vpn | input | 20 | Virtual page number for the entry |
| wr_asid | input | 8 | ASID of the entry |
| wr_ppn | input | 20 | Physical page number of the entry |
| wr_shared | input | 1 | Entry matches under any ASID |
| wr_cacheable | input | 1 | Entry is cacheable |
| inval_all | input | 1 | Clear every entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found, or fixed window |
| rsp_miss | output | 1 | Translated region, no matching way |
| rsp_multi_hit | output | 1 | More than one way matched |
| rsp_addr_err | output | 1 | Reserved user-region address |
| rsp_ctrl | output | 1 | Control region address |
| rsp_pa | output | 32 | Physical address, valid with rsp_hit |
| rsp_cacheable | output | 1 | Cacheable attribute, valid with rsp_hit |

## Verification
The region checks probe addresses on each side of every region boundary. They include both edges of the reserved 64 MiB and one address just below it, which separates the address-error decode from ordinary translation. Translated lookups are run twice with the same address: once with a matching ASID and once with a mismatched ASID, with and without the shared bit. This shows whether the ASID compare and the shared override are both in use. The same entry is then looked up with index_mode set and cleared, which shows that the hashed set is the one being used. Two ways are loaded with the same page to force a multi-hit. One of those ways is then rewritten, and a lookup after a global invalidate checks that no entry survives it.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;

    localparam int VA_W     = 32;
    localparam int OFS_W    = 12;
    localparam int VPN_W    = VA_W - OFS_W;
    localparam int PPN_W    = 20;
    localparam int ASID_W   = 8;
    localparam int N_SETS   = 32;
    localparam int N_WAYS   = 4;
    localparam int SET_W    = $clog2(N_SETS);
    localparam int WAY_W    = $clog2(N_WAYS);
    localparam int TAG_HI_W = VPN_W - SET_W;
    localparam int WIN_W    = 29;

    typedef enum logic [2:0] {
        RG_USER     = 3'd0,
        RG_USER_BAD = 3'd1,
        RG_FIX_C    = 3'd2,
        RG_FIX_U    = 3'd3,
        RG_KERN     = 3'd4,
        RG_CTRL     = 3'd5
    } region_e;

    typedef struct packed {
        logic [ASID_W-1:0]   asid;
        logic [TAG_HI_W-1:0] tag_hi;
        logic [SET_W-1:0]    tag_lo;
        logic                shared;
        logic [PPN_W-1:0]    ppn;
        logic                cacheable;
    } entry_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic              multi;
        logic              addr_err;
        logic              ctrl;
        logic [VA_W-1:0]   pa;
        logic              cacheable;
    } result_t;

    function automatic region_e classify(input logic [VA_W-1:0] va);
        region_e r;
        case (va[VA_W-1 -: 3])
            3'b000, 3'b001, 3'b010: r = RG_USER;
            3'b011:  r = (va[VA_W-4 -: 3] == 3'b111) ? RG_USER_BAD : RG_USER;
            3'b100:  r = RG_FIX_C;
            3'b101:  r = RG_FIX_U;
            3'b110:  r = RG_KERN;
            default: r = RG_CTRL;
        endcase
        return r;
    endfunction

    function automatic logic [SET_W-1:0] set_of(input logic hashed,
                                                input logic [ASID_W-1:0] asid,
                                                input logic [SET_W-1:0] vpn_lo);
        return hashed ? (vpn_lo ^ asid[SET_W-1:0]) : vpn_lo;
    endfunction

endpackage

// File: rtl/tlb_region_decode.sv
module tlb_region_decode
    import tlb_lookup_pkg::*;
(
    input  logic [VA_W-1:0] va,
    output region_e         region,
    output logic            translated,
    output logic [VA_W-1:0] window_pa
);
    always_comb begin
        region     = classify(va);
        translated = (region == RG_USER) || (region == RG_KERN);
        window_pa  = {{(VA_W-WIN_W){1'b0}}, va[WIN_W-1:0]};
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_lookup_pkg::*;
#(
    parameter int SETS = N_SETS,
    parameter int WAYS = N_WAYS,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          inval_all,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  logic [WW-1:0] wr_way,
    input  entry_t        wr_entry,
    input  logic [SW-1:0] rd_set,
    output entry_t        rd_entry [WAYS],
    output logic [WAYS-1:0] rd_valid
);
    entry_t          mem [SETS][WAYS];
    logic [WAYS-1:0] vld [SETS];
    logic            any_valid;

    always_ff @(posedge clk) begin
        if (rst || inval_all) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else if (wr_en) begin
            vld[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_set][wr_way] <= wr_entry;
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_rd
            assign rd_entry[w] = mem[rd_set][w];
            assign rd_valid[w] = vld[rd_set][w];
        end
    endgenerate

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld[s]);
    end

    p_inval_clears_r12: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !any_valid);
    p_write_sets_valid_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inval_all) |=> any_valid);
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_lookup_pkg::*;
(
    input  entry_t            entry,
    input  logic              entry_valid,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              hashed,
    output logic              match
);
    logic hi_ok, lo_ok, asid_ok;

    always_comb begin
        hi_ok   = (entry.tag_hi == vpn[VPN_W-1:SET_W]);
        lo_ok   = hashed || (entry.tag_lo == vpn[SET_W-1:0]);
        asid_ok = entry.shared || (entry.asid == cur_asid);
        match   = entry_valid && hi_ok && lo_ok && asid_ok;
    end
endmodule

// File: rtl/tlb_asid_lookup.sv
module tlb_asid_lookup
    import tlb_lookup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              index_mode,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_shared,
    input  logic              wr_cacheable,
    input  logic              inval_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_multi_hit,
    output logic              rsp_addr_err,
    output logic              rsp_ctrl,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_cacheable
);
    region_e          region;
    logic             translated;
    logic [VA_W-1:0]  window_pa;
    logic [VPN_W-1:0] vpn;
    logic [SET_W-1:0] rd_set;
    entry_t           way_entry [N_WAYS];
    logic [N_WAYS-1:0] way_valid;
    logic [N_WAYS-1:0] way_match;
    entry_t           wr_entry;
    entry_t           sel;
    result_t          nxt, res_q;

    assign vpn = req_va[VA_W-1:OFS_W];

    tlb_region_decode u_region (
        .va         (req_va),
        .region     (region),
        .translated (translated),
        .window_pa  (window_pa)
    );

    always_comb begin
        rd_set             = set_of(index_mode, cur_asid, vpn[SET_W-1:0]);
        wr_entry.asid      = wr_asid;
        wr_entry.tag_hi    = wr_vpn[VPN_W-1:SET_W];
        wr_entry.tag_lo    = index_mode ? '0 : wr_vpn[SET_W-1:0];
        wr_entry.shared    = wr_shared;
        wr_entry.ppn       = wr_ppn;
        wr_entry.cacheable = wr_cacheable;
    end

    tlb_entry_store #(.SETS(N_SETS), .WAYS(N_WAYS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .inval_all (inval_all),
        .wr_en     (wr_en),
        .wr_set    (wr_set),
        .wr_way    (wr_way),
        .wr_entry  (wr_entry),
        .rd_set    (rd_set),
        .rd_entry  (way_entry),
        .rd_valid  (way_valid)
    );

    generate
        for (genvar w = 0; w < N_WAYS; w++) begin : g_way
            tlb_way_match u_match (
                .entry       (way_entry[w]),
                .entry_valid (way_valid[w]),
                .vpn         (vpn),
                .cur_asid    (cur_asid),
                .hashed      (index_mode),
                .match       (way_match[w])
            );
        end
    endgenerate

    always_comb begin
        sel = '0;
        for (int w = 0; w < N_WAYS; w++) begin
            if (way_match[w]) sel = sel | way_entry[w];
        end
    end

    always_comb begin
        nxt = '0;
        if (req_valid) begin
            nxt.valid = 1'b1;
            case (region)
                RG_FIX_C: begin
                    nxt.hit = 1'b1; nxt.pa = window_pa; nxt.cacheable = 1'b1;
                end
                RG_FIX_U: begin
                    nxt.hit = 1'b1; nxt.pa = window_pa;
                end
                RG_USER_BAD: nxt.addr_err = 1'b1;
                RG_CTRL:     nxt.ctrl = 1'b1;
                default: begin
                    if ($countones(way_match) > 1) begin
                        nxt.multi = 1'b1;
                    end else if (way_match != '0) begin
                        nxt.hit       = 1'b1;
                        nxt.pa        = {sel.ppn, req_va[OFS_W-1:0]};
                        nxt.cacheable = sel.cacheable;
                    end else begin
                        nxt.miss = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign rsp_valid     = res_q.valid;
    assign rsp_hit       = res_q.hit;
    assign rsp_miss      = res_q.miss;
    assign rsp_multi_hit = res_q.multi;
    assign rsp_addr_err  = res_q.addr_err;
    assign rsp_ctrl      = res_q.ctrl;
    assign rsp_pa        = res_q.pa;
    assign rsp_cacheable = res_q.cacheable;

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_multi_hit, rsp_addr_err, rsp_ctrl}));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_multi_hit || rsp_addr_err || rsp_ctrl));
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_window_pa_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:30] == 2'b10) |=>
            (rsp_hit && rsp_pa == {3'b000, $past(req_va[28:0])}));
    p_reserved_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:26] == 6'b011111) |=> rsp_addr_err);
    p_ctrl_space_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:29] == 3'b111) |=> (rsp_ctrl && !rsp_hit));
endmodule

// File: tb/test_tlb_asid_lookup.sv
module test_tlb_asid_lookup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cur_asid = '0;
    logic        index_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_set = '0;
    logic [1:0]  wr_way = '0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [19:0] wr_ppn = '0;
    logic        wr_shared = 1'b0;
    logic        wr_cacheable = 1'b0;
    logic        inval_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi_hit, rsp_addr_err, rsp_ctrl;
    logic [31:0] rsp_pa;
    logic        rsp_cacheable;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tlb_asid_lookup i_tlb_asid_lookup (
        .clk(clk), .rst(rst), .cur_asid(cur_asid), .index_mode(index_mode),
        .req_valid(req_valid), .req_va(req_va),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_shared(wr_shared),
        .wr_cacheable(wr_cacheable), .inval_all(inval_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_multi_hit(rsp_multi_hit), .rsp_addr_err(rsp_addr_err),
        .rsp_ctrl(rsp_ctrl), .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // outcome vector {hit, miss, multi, addr_err, ctrl}
    task automatic expect_rsp(input string req, input logic [4:0] flags,
                              input logic [31:0] pa, input logic c);
        check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " flags"}, {27'd0, rsp_hit, rsp_miss, rsp_multi_hit, rsp_addr_err, rsp_ctrl},
              {27'd0, flags});
        if (flags[4]) begin
            check({req, " pa"}, rsp_pa, pa);
            check({req, " cacheable"}, {31'd0, rsp_cacheable}, {31'd0, c});
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic mode);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; cur_asid = asid; index_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load(input logic [4:0] set, input logic [1:0] way, input logic [19:0] vpn,
                        input logic [7:0] asid, input logic [19:0] ppn,
                        input logic sh, input logic c, input logic mode);
        @(negedge clk);
        wr_en = 1'b1; wr_set = set; wr_way = way; wr_vpn = vpn; wr_asid = asid;
        wr_ppn = ppn; wr_shared = sh; wr_cacheable = c; index_mode = mode;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        lookup(32'h0012_3456, 8'h21, 1'b0);
        expect_rsp("R1 empty miss", 5'b01000, 32'd0, 1'b0);
        @(negedge clk);
        check("R2 idle no response", {26'd0, rsp_valid, rsp_hit, rsp_miss, rsp_multi_hit,
              rsp_addr_err, rsp_ctrl}, 32'd0);
    endtask

    task automatic t_regions;
        lookup(32'h8123_4567, 8'h00, 1'b0);
        expect_rsp("R3 cached window", 5'b10000, 32'h0123_4567, 1'b1);
        lookup(32'h9FFF_FFFF, 8'h00, 1'b0);
        expect_rsp("R3 cached window top", 5'b10000, 32'h1FFF_FFFF, 1'b1);
        lookup(32'hA123_4567, 8'h00, 1'b0);
        expect_rsp("R4 uncached window", 5'b10000, 32'h0123_4567, 1'b0);
        lookup(32'hE000_0010, 8'h00, 1'b0);
        expect_rsp("R5 control space", 5'b00001, 32'd0, 1'b0);
        lookup(32'h7C00_0000, 8'h00, 1'b0);
        expect_rsp("R6 reserved low edge", 5'b00010, 32'd0, 1'b0);
        lookup(32'h7FFF_FFFC, 8'h00, 1'b0);
        expect_rsp("R6 reserved high edge", 5'b00010, 32'd0, 1'b0);
        lookup(32'h7BFF_F000, 8'h00, 1'b0);
        expect_rsp("R6 below reserved translates", 5'b01000, 32'd0, 1'b0);
    endtask

    task automatic t_translate;
        load(5'd3, 2'd0, 20'h00123, 8'h21, 20'h45678, 1'b0, 1'b1, 1'b0);
        lookup(32'h0012_3456, 8'h21, 1'b0);
        expect_rsp("R7 R10 user hit", 5'b10000, 32'h4567_8456, 1'b1);
        lookup(32'h0012_3456, 8'h22, 1'b0);
        expect_rsp("R8 asid mismatch miss", 5'b01000, 32'd0, 1'b0);
        lookup(32'h0013_3456, 8'h21, 1'b0);
        expect_rsp("R10 low vpn differs miss", 5'b01000, 32'd0, 1'b0);
        load(5'd3, 2'd1, 20'h00C23, 8'h55, 20'h11111, 1'b1, 1'b0, 1'b0);
        lookup(32'h00C2_3ABC, 8'h22, 1'b0);
        expect_rsp("R8 shared hit", 5'b10000, 32'h1111_1ABC, 1'b0);
    endtask

    task automatic t_hash;
        // set = 0x0A ^ 0x07 = 0x0D
        load(5'd13, 2'd2, 20'hC0047, 8'h0A, 20'h0ABCD, 1'b0, 1'b1, 1'b1);
        lookup(32'hC004_7010, 8'h0A, 1'b1);
        expect_rsp("R9 hashed kernel hit", 5'b10000, 32'h0ABC_D010, 1'b1);
        lookup(32'hC004_7010, 8'h0A, 1'b0);
        expect_rsp("R10 unhashed index misses", 5'b01000, 32'd0, 1'b0);
    endtask

    task automatic t_multi;
        load(5'd20, 2'd0, 20'h00014, 8'h21, 20'h00AAA, 1'b0, 1'b1, 1'b0);
        load(5'd20, 2'd3, 20'h00014, 8'h21, 20'h00BBB, 1'b0, 1'b1, 1'b0);
        lookup(32'h0001_4000, 8'h21, 1'b0);
        expect_rsp("R11 multi hit", 5'b00100, 32'd0, 1'b0);
        load(5'd20, 2'd3, 20'h00034, 8'h21, 20'h00CCC, 1'b0, 1'b0, 1'b0);
        lookup(32'h0001_4000, 8'h21, 1'b0);
        expect_rsp("R13 overwrite leaves one hit", 5'b10000, 32'h00AA_A000, 1'b1);
        lookup(32'h0003_4004, 8'h21, 1'b0);
        expect_rsp("R13 new entry hit", 5'b10000, 32'h00CC_C004, 1'b0);
    endtask

    task automatic t_invalidate;
        @(negedge clk);
        inval_all = 1'b1;
        wr_en = 1'b1; wr_set = 5'd9; wr_way = 2'd1; wr_vpn = 20'h00009;
        wr_asid = 8'h21; wr_ppn = 20'h00999; index_mode = 1'b0;
        @(negedge clk);
        inval_all = 1'b0; wr_en = 1'b0;
        lookup(32'h0012_3456, 8'h21, 1'b0);
        expect_rsp("R12 cleared entry miss", 5'b01000, 32'd0, 1'b0);
        lookup(32'h0000_9000, 8'h21, 1'b0);
        expect_rsp("R12 invalidate beats write", 5'b01000, 32'd0, 1'b0);
        lookup(32'h8000_0000, 8'h21, 1'b0);
        expect_rsp("R3 window unaffected", 5'b10000, 32'h0000_0000, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regions();
        t_translate();
        t_hash();
        t_multi();
        t_invalidate();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule